// File: doc/BRIEF.md
# Factory Mode Charger Controller

This block decides whether a charger is running in the no-battery factory condition. It also produces the digital enables and charge settings that the charger analog circuits need in that condition.

The factory condition is recognised only at attach. The block samples the identification line when the bus supply first becomes valid. If that line is high at that moment, the block enters factory mode. A valid bus supply with the identification line low is an ordinary host attach, and the charger stays in its normal configuration.

In factory mode the enables depend on the power-path strap:
- **Serial path** (a series battery switch sits between the system rail and the battery): the input switches are driven fully on and the battery switch is opened. The trickle source, every timer and the power limiter are switched off.
- **Single path**: charging behaves as normal at the minimum current code. Only the charge timer and the power limiter are switched off.

Software can rewrite the charge current and voltage codes only while it holds the program-enable bit in factory mode. Software leaves factory mode with the exit bit. Loss of the bus supply also ends factory mode and returns everything to its defaults.

Top module: `fact_chg_ctrl`

## Requirements
- R1: While and after synchronous reset, fact_mode=0, main_sw_full=0, batt_sw_on=1, trickle_en=1, int_tmr_en=1, pre_tmr_en=1, chg_tmr_en=1, plim_en=1, chg_cur_code=CUR_MIN (default 0) and chg_volt_code=VOLT_DEF (default 4).
- R2: On the clock edge where vbus_ok is first seen high after having been low, fact_mode becomes uid_hi as sampled at that edge. All outputs reflect the new mode after that same edge.
- R3: While vbus_ok stays high, changes of uid_hi neither enter nor leave factory mode.
- R4: In factory mode with path_serial=1, outputs are main_sw_full=1, batt_sw_on=0, trickle_en=0, int_tmr_en=0, pre_tmr_en=0, chg_tmr_en=0 and plim_en=0.
- R5: In factory mode with path_serial=0, outputs are main_sw_full=1, batt_sw_on=1, trickle_en=1, int_tmr_en=1, pre_tmr_en=1, chg_tmr_en=0 and plim_en=0. The enables follow the path strap one edge after it changes.
- R6: In factory mode, an edge with prog_en=1 and wr_en=1 loads wr_cur into chg_cur_code and wr_volt into chg_volt_code after that edge.
- R7: A write with prog_en=0, or outside factory mode, leaves chg_cur_code and chg_volt_code unchanged.
- R8: An edge with exit_req=1 in factory mode clears fact_mode and restores the R1 output values. Factory mode is not re-entered until a new low-to-high transition of vbus_ok.
- R9: An edge with vbus_ok=0 clears fact_mode and restores every output to its R1 value, including the written charge codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vbus_ok | input | 1 | Bus supply valid flag |
| uid_hi | input | 1 | Identification line sensed at bus level |
| path_serial | input | 1 | 1 = serial path with series battery switch, 0 = single path |
| prog_en | input | 1 | Software program-enable bit |
| exit_req | input | 1 | Software factory-exit bit |
| wr_en | input | 1 | Charge-setting write strobe |
| wr_cur | input | CUR_W | Charge current code to write |
| wr_volt | input | VOLT_W | Charge voltage code to write |
| fact_mode | output | 1 | Factory mode active |
| main_sw_full | output | 1 | Drive input switches fully on |
| batt_sw_on | output | 1 | Series battery switch closed |
| trickle_en | output | 1 | Trickle current source enable |
| int_tmr_en | output | 1 | Internal timers enable |
| pre_tmr_en | output | 1 | Precharge timer enable |
| chg_tmr_en | output | 1 | Charge timer enable |
| plim_en | output | 1 | Power limiter enable |
| chg_cur_code | output | CUR_W | Selected charge current code |
| chg_volt_code | output | VOLT_W | Selected charge voltage code |

## Verification
The bench sweeps the identification level, the path strap, the program bit and every current code. This exposes four kinds of fault:
- A design that samples the identification line continuously instead of at attach would change mode when the line flips mid-session.
- A design that re-qualifies on a held supply would re-enter factory mode after exit.
- Swapped enable sets for the two paths show up directly in the enables.
- A write that ignores the program bit, or settings that survive exit, supply loss or reset, show up as wrong current or voltage codes.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

  typedef struct packed {
    logic main_full;
    logic batt_sw_on;
    logic trickle_en;
    logic int_tmr_en;
    logic pre_tmr_en;
    logic chg_tmr_en;
    logic plim_en;
  } chg_en_t;

  localparam int EN_W = $bits(chg_en_t);

  localparam chg_en_t EN_NORMAL = '{main_full: 1'b0, batt_sw_on: 1'b1,
                                    trickle_en: 1'b1, int_tmr_en: 1'b1,
                                    pre_tmr_en: 1'b1, chg_tmr_en: 1'b1,
                                    plim_en: 1'b1};

  localparam chg_en_t EN_FACT_SERIAL = '{main_full: 1'b1, batt_sw_on: 1'b0,
                                        trickle_en: 1'b0, int_tmr_en: 1'b0,
                                        pre_tmr_en: 1'b0, chg_tmr_en: 1'b0,
                                        plim_en: 1'b0};

  localparam chg_en_t EN_FACT_SINGLE = '{main_full: 1'b1, batt_sw_on: 1'b1,
                                        trickle_en: 1'b1, int_tmr_en: 1'b1,
                                        pre_tmr_en: 1'b1, chg_tmr_en: 1'b0,
                                        plim_en: 1'b0};

  function automatic chg_en_t map_enables(input logic fact, input logic serial);
    chg_en_t r;
    if (!fact)       r = EN_NORMAL;
    else if (serial) r = EN_FACT_SERIAL;
    else             r = EN_FACT_SINGLE;
    return r;
  endfunction

endpackage

// File: rtl/fmc_attach.sv
module fmc_attach (
  input  logic clk,
  input  logic rst,
  input  logic vbus_ok,
  input  logic uid_hi,
  input  logic exit_req,
  output logic fact_nxt,
  output logic fact_mode
);

  logic vbus_q;
  logic attach_edge;

  assign attach_edge = vbus_ok & ~vbus_q;

  always_comb begin
    if (!vbus_ok)         fact_nxt = 1'b0;
    else if (attach_edge) fact_nxt = uid_hi;
    else if (exit_req)    fact_nxt = 1'b0;
    else                  fact_nxt = fact_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbus_q    <= 1'b0;
      fact_mode <= 1'b0;
    end else begin
      vbus_q    <= vbus_ok;
      fact_mode <= fact_nxt;
    end
  end

  AST_ENTRY_NEEDS_UID: assert property (@(posedge clk) disable iff (rst)
    $rose(fact_mode) |-> ($past(uid_hi) && $past(vbus_ok)));  // R2

  AST_NO_LATE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!fact_mode && vbus_ok && $past(vbus_ok) && $past(!rst)) |=> !fact_mode);  // R3

  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (fact_mode && exit_req) |=> !fact_mode);  // R8

  AST_VBUS_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !vbus_ok |=> !fact_mode);  // R9

endmodule

// File: rtl/fmc_en_map.sv
module fmc_en_map
  import fmc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    fact_nxt,
  input  logic    path_serial,
  output chg_en_t en_q
);

  always_ff @(posedge clk) begin
    if (rst) en_q <= EN_NORMAL;
    else     en_q <= map_enables(fact_nxt, path_serial);
  end

  AST_FACT_LIMITS_OFF: assert property (@(posedge clk) disable iff (rst)
    (en_q.main_full) |-> (!en_q.chg_tmr_en && !en_q.plim_en));  // R4

  AST_SERIAL_NO_TRICKLE: assert property (@(posedge clk) disable iff (rst)
    (en_q.main_full && !en_q.batt_sw_on) |-> (!en_q.trickle_en && !en_q.pre_tmr_en && !en_q.int_tmr_en));  // R4

  AST_SINGLE_KEEPS_TIMERS: assert property (@(posedge clk) disable iff (rst)
    (en_q.main_full && en_q.batt_sw_on) |-> (en_q.int_tmr_en && en_q.pre_tmr_en && en_q.trickle_en));  // R5

endmodule

// File: rtl/fmc_cfg_reg.sv
module fmc_cfg_reg #(
  parameter int                CUR_W    = 4,
  parameter int                VOLT_W   = 3,
  parameter logic [CUR_W-1:0]  CUR_MIN  = '0,
  parameter logic [VOLT_W-1:0] VOLT_DEF = VOLT_W'(4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fact_mode,
  input  logic              fact_nxt,
  input  logic              prog_en,
  input  logic              wr_en,
  input  logic [CUR_W-1:0]  wr_cur,
  input  logic [VOLT_W-1:0] wr_volt,
  output logic [CUR_W-1:0]  cur_q,
  output logic [VOLT_W-1:0] volt_q
);

  logic wr_ok;

  assign wr_ok = fact_mode & prog_en & wr_en;

  always_ff @(posedge clk) begin
    if (rst || !fact_nxt) begin
      cur_q  <= CUR_MIN;
      volt_q <= VOLT_DEF;
    end else if (wr_ok) begin
      cur_q  <= wr_cur;
      volt_q <= wr_volt;
    end
  end

  AST_NO_WRITE_WITHOUT_PROG: assert property (@(posedge clk) disable iff (rst)
    (fact_mode && !(prog_en && wr_en)) |=> (!fact_mode || ($stable(cur_q) && $stable(volt_q))));  // R7

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (fact_mode && prog_en && wr_en) |=> (!fact_mode || (cur_q == $past(wr_cur) && volt_q == $past(wr_volt))));  // R6

  AST_DEFAULTS_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    !fact_mode |-> (cur_q == CUR_MIN && volt_q == VOLT_DEF));  // R9

endmodule

// File: rtl/fact_chg_ctrl.sv
module fact_chg_ctrl
  import fmc_pkg::*;
#(
  parameter int                CUR_W    = 4,
  parameter int                VOLT_W   = 3,
  parameter logic [CUR_W-1:0]  CUR_MIN  = '0,
  parameter logic [VOLT_W-1:0] VOLT_DEF = VOLT_W'(4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vbus_ok,
  input  logic              uid_hi,
  input  logic              path_serial,
  input  logic              prog_en,
  input  logic              exit_req,
  input  logic              wr_en,
  input  logic [CUR_W-1:0]  wr_cur,
  input  logic [VOLT_W-1:0] wr_volt,
  output logic              fact_mode,
  output logic              main_sw_full,
  output logic              batt_sw_on,
  output logic              trickle_en,
  output logic              int_tmr_en,
  output logic              pre_tmr_en,
  output logic              chg_tmr_en,
  output logic              plim_en,
  output logic [CUR_W-1:0]  chg_cur_code,
  output logic [VOLT_W-1:0] chg_volt_code
);

  logic    fact_nxt;
  chg_en_t en_q;

  fmc_attach u_attach (
    .clk       (clk),
    .rst       (rst),
    .vbus_ok   (vbus_ok),
    .uid_hi    (uid_hi),
    .exit_req  (exit_req),
    .fact_nxt  (fact_nxt),
    .fact_mode (fact_mode)
  );

  fmc_en_map u_en_map (
    .clk         (clk),
    .rst         (rst),
    .fact_nxt    (fact_nxt),
    .path_serial (path_serial),
    .en_q        (en_q)
  );

  fmc_cfg_reg #(
    .CUR_W    (CUR_W),
    .VOLT_W   (VOLT_W),
    .CUR_MIN  (CUR_MIN),
    .VOLT_DEF (VOLT_DEF)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .fact_mode (fact_mode),
    .fact_nxt  (fact_nxt),
    .prog_en   (prog_en),
    .wr_en     (wr_en),
    .wr_cur    (wr_cur),
    .wr_volt   (wr_volt),
    .cur_q     (chg_cur_code),
    .volt_q    (chg_volt_code)
  );

  assign main_sw_full = en_q.main_full;
  assign batt_sw_on   = en_q.batt_sw_on;
  assign trickle_en   = en_q.trickle_en;
  assign int_tmr_en   = en_q.int_tmr_en;
  assign pre_tmr_en   = en_q.pre_tmr_en;
  assign chg_tmr_en   = en_q.chg_tmr_en;
  assign plim_en      = en_q.plim_en;

  AST_MODE_MATCHES_SWITCH: assert property (@(posedge clk) disable iff (rst)
    fact_mode |-> (main_sw_full && !chg_tmr_en && !plim_en));  // R4

  AST_NORMAL_ENABLES: assert property (@(posedge clk) disable iff (rst)
    !fact_mode |-> (!main_sw_full && batt_sw_on && trickle_en && chg_tmr_en && plim_en));  // R1

endmodule

// File: tb/fact_chg_ctrl_tb.sv
module fact_chg_ctrl_tb;

  localparam int CUR_W  = 4;
  localparam int VOLT_W = 3;
  localparam logic [CUR_W-1:0]  CMIN = '0;
  localparam logic [VOLT_W-1:0] VDEF = 3'd4;

  logic clk = 1'b0;
  logic rst, vbus_ok, uid_hi, path_serial, prog_en, exit_req, wr_en;
  logic [CUR_W-1:0]  wr_cur;
  logic [VOLT_W-1:0] wr_volt;
  logic fact_mode, main_sw_full, batt_sw_on, trickle_en, int_tmr_en;
  logic pre_tmr_en, chg_tmr_en, plim_en;
  logic [CUR_W-1:0]  chg_cur_code;
  logic [VOLT_W-1:0] chg_volt_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic ef;
  logic [CUR_W-1:0]  ecur;
  logic [VOLT_W-1:0] evolt;

  always #10 clk = ~clk;

  fact_chg_ctrl u_dut (
    .clk(clk), .rst(rst), .vbus_ok(vbus_ok), .uid_hi(uid_hi),
    .path_serial(path_serial), .prog_en(prog_en), .exit_req(exit_req),
    .wr_en(wr_en), .wr_cur(wr_cur), .wr_volt(wr_volt),
    .fact_mode(fact_mode), .main_sw_full(main_sw_full), .batt_sw_on(batt_sw_on),
    .trickle_en(trickle_en), .int_tmr_en(int_tmr_en), .pre_tmr_en(pre_tmr_en),
    .chg_tmr_en(chg_tmr_en), .plim_en(plim_en),
    .chg_cur_code(chg_cur_code), .chg_volt_code(chg_volt_code)
  );

  function automatic logic [14:0] expect_vec(logic f, logic s,
                                             logic [3:0] c, logic [2:0] v);
    logic [6:0] en;
    if (!f)     en = 7'b0111111;
    else if (s) en = 7'b1000000;
    else        en = 7'b1111100;
    return f ? {1'b1, en, c, v} : {1'b0, en, CMIN, VDEF};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req);
    logic [14:0] act, exp;
    act = {fact_mode, main_sw_full, batt_sw_on, trickle_en, int_tmr_en,
           pre_tmr_en, chg_tmr_en, plim_en, chg_cur_code, chg_volt_code};
    exp = expect_vec(ef, path_serial, ecur, evolt);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clear_exp();
    ef = 1'b0; ecur = CMIN; evolt = VDEF;
  endtask

  initial begin
    rst = 1'b1; vbus_ok = 0; uid_hi = 0; path_serial = 0; prog_en = 0;
    exit_req = 0; wr_en = 0; wr_cur = '0; wr_volt = '0;
    clear_exp();
    @(negedge clk);
    step();
    chk("R1");
    rst = 1'b0;
    step();
    chk("R1");

    for (int u = 0; u < 2; u++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 2; p++) begin
          for (int w = 0; w < 16; w++) begin
            vbus_ok = 0; step(); clear_exp(); chk("R9");
            uid_hi = u[0]; path_serial = s[0]; vbus_ok = 1; step();
            ef = u[0];
            chk(s ? "R2 R4" : "R2 R5");
            uid_hi = ~u[0]; step(); chk("R3");
            wr_en = 1; prog_en = p[0]; wr_cur = w[3:0]; wr_volt = 3'(w * 3);
            step();
            wr_en = 0; prog_en = 0;
            if (ef && p[0]) begin ecur = w[3:0]; evolt = 3'(w * 3); chk("R6"); end
            else chk("R7");
            path_serial = ~s[0]; step(); chk("R5");
            path_serial = s[0]; step(); chk("R4");
            exit_req = 1; step(); exit_req = 0; clear_exp(); chk("R8");
            uid_hi = 1; step(); chk("R8");
          end
        end
      end
    end

    vbus_ok = 0; step(); clear_exp();
    uid_hi = 1; path_serial = 1; vbus_ok = 1; step(); ef = 1; chk("R2");
    wr_en = 1; prog_en = 1; wr_cur = 4'd9; wr_volt = 3'd6; step();
    wr_en = 0; prog_en = 0; ecur = 4'd9; evolt = 3'd6; chk("R6");
    vbus_ok = 0; step(); clear_exp(); chk("R9");
    vbus_ok = 1; step(); ef = 1; chk("R2");
    wr_en = 1; prog_en = 1; wr_cur = 4'd13; wr_volt = 3'd1; step();
    wr_en = 0; prog_en = 0; ecur = 4'd13; evolt = 3'd1; chk("R6");
    rst = 1; step(); clear_exp(); chk("R1");
    rst = 0; step(); ef = 1; chk("R2");
    exit_req = 1; uid_hi = 1; step(); exit_req = 0; clear_exp(); chk("R8");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule